// File: doc/BRIEF.md
# Successive-Approximation ADC Timing Sequencer

This block runs the timing of one successive-approximation conversion from the bus clock. An 8-bit control register holds three settings: a prescale value that sets the conversion-clock rate, a code that sets the length of the second sampling phase, and a flag that picks the result width. The block does not make a second clock. It makes a one-cycle enable that fires once every 2 × (prescale + 1) bus cycles, and it times every phase in units of that enable.

After a start request the block runs four steps in order. First comes a buffered sampling phase of two conversion-clock periods. Next comes a direct-charge sampling phase of selectable length. Then there is one decision period per result bit, working from the most significant bit down. The block shows a trial code to the analog front end, reads back one comparator bit, and keeps or clears the trial bit. When the last bit is decided, the block writes the result word and pulses a done flag. A write to the control register stops any conversion in progress and does not start a new one.

Top module: `sar_timing_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x05. `busy`, `done`, `samp_buf`, `samp_dir` and `conv_act` are low, and `result` is zero.
- R2: The control register can be written and read back at any time. Bit 7 is the low-resolution flag, bits 6:5 are the sampling-length code and bits 4:0 are the prescale value P.
- R3: The conversion-clock period is 2 × (P+1) bus cycles. It is counted from the cycle in which the start is accepted, so a full conversion keeps `busy` high for exactly 2(P+1) × (2 + N + B) cycles.
- R4: `samp_buf` goes high in the cycle after a start is accepted and stays high for exactly 2 conversion-clock periods.
- R5: `samp_dir` follows at once and stays high for N conversion-clock periods. N is 2, 4, 8 or 16 for codes 0, 1, 2 and 3.
- R6: `conv_act` follows at once and stays high for B conversion-clock periods. B is 10 when bit 7 is 0 and 8 when bit 7 is 1.
- R7: During `conv_act`, `dac_code` shows the bits decided so far plus the bit under test, starting with bit 9 alone. At each period end the bit is kept if `cmp_in` is 1. With a comparator that reports input ≥ `dac_code`, a 10-bit result equals the input code.
- R8: In 8-bit mode the 8 decided bits sit in `result[9:2]` and `result[1:0]` are zero.
- R9: `done` is high for exactly one cycle, in the cycle right after `busy` falls at the end of a conversion. `result` changes only in that cycle and holds its value until the next completed conversion.
- R10: `busy` is high from the cycle after an accepted start until completion or abort. A start while busy is ignored and does not lengthen the conversion.
- R11: A register write during a conversion drops `busy` in the next cycle, gives no `done` and leaves `result` unchanged. No new conversion starts. A write in the same cycle as a start wins, and the start is dropped.
- R12: At most one of `samp_buf`, `samp_dir` and `conv_act` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| start | input | 1 | Conversion start request |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |
| samp_buf | output | 1 | Buffered sampling phase strobe |
| samp_dir | output | 1 | Direct-charge sampling phase strobe |
| conv_act | output | 1 | Bit-decision phase strobe |
| dac_code | output | 10 | Trial code for the front end during decisions, zero otherwise |
| result | output | 10 | Last completed conversion result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Conversion in progress |

## Verification
The bench measures each phase length at the extremes of the prescale range (0 and 31) and for every sampling-length code. A divider that is off by one, or that counts from a free-running phase, would make the busy window too long or too short. It drives all-ones, all-zero and alternating input codes in both widths. An 8-bit run with nonzero low input bits exposes a design that decides the low bits or right-aligns the result. Aborts are tested mid-conversion, alongside a start in the same cycle as a write and a second start during a busy period. A design that only paused on a write, restarted after it, or let a start take priority would show a `done`, a changed result or a longer `busy`.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Field widths of the control register; the packed order fixes bit positions.
    localparam int unsigned PRS_W = 5;
    localparam int unsigned SMP_W = 2;
    localparam int unsigned CFG_W = 1 + SMP_W + PRS_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUF  = 2'd1,
        ST_DIR  = 2'd2,
        ST_CONV = 2'd3
    } seq_state_e;

    // bit 7: low-resolution flag, bits 6:5: sampling length, bits 4:0: prescale
    typedef struct packed {
        logic             res_low;
        logic [SMP_W-1:0] smp_len;
        logic [PRS_W-1:0] prs;
    } seq_cfg_t;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int unsigned PRS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PRS_W-1:0] prs,
    output logic             tick
);
    localparam int unsigned CNT_W = PRS_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t         st_d, st_q;
    logic [CNT_W-1:0] wrap_at;

    // The period is 2*(prs+1) cycles, so the terminal count is 2*prs+1.
    always_comb begin
        wrap_at = {prs, 1'b1};
        st_d    = st_q;
        tick    = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt == wrap_at) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int unsigned RES_W    = 10,
    parameter int unsigned LOW_DROP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             cmp,
    input  logic             short_mode,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] decided,
    output logic             last
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic [RES_W-1:0] acc;
        logic [RES_W-1:0] mask;
    } sar_st_t;

    sar_st_t st_d, st_q;

    assign trial   = st_q.acc | st_q.mask;
    assign decided = cmp ? trial : st_q.acc;

    // The final bit depends on the width mode; without dropped bits both modes end at bit 0.
    generate
        if (LOW_DROP > 0) begin : g_short
            assign last = short_mode ? st_q.mask[LOW_DROP] : st_q.mask[0];
        end else begin : g_full
            assign last = st_q.mask[0];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.acc  = '0;
            st_d.mask = TOP_BIT;
        end else if (step) begin
            st_d.acc  = decided;
            st_d.mask = st_q.mask >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int unsigned SMP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic [SMP_W-1:0] smp_len,
    input  logic             last,
    output seq_state_e       state,
    output logic             restart,
    output logic             step,
    output logic             finish
);
    // The longest direct phase is 2 << (2**SMP_W - 1) periods; one more bit than its log.
    localparam int unsigned PH_W = (1 << SMP_W) + 1;

    typedef struct packed {
        seq_state_e      st;
        logic [PH_W-1:0] cnt;
    } fsm_st_t;

    fsm_st_t         st_d, st_q;
    logic [PH_W-1:0] dir_end;

    assign state = st_q.st;

    always_comb begin
        dir_end = (PH_W'(2) << smp_len) - 1'b1;
        st_d    = st_q;
        restart = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        if (abort) begin
            st_d.st  = ST_IDLE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.st)
                ST_IDLE: begin
                    if (start) begin
                        st_d.st  = ST_BUF;
                        st_d.cnt = '0;
                        restart  = 1'b1;
                    end
                end
                ST_BUF: begin
                    if (tick) begin
                        if (st_q.cnt == PH_W'(1)) begin
                            st_d.st  = ST_DIR;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DIR: begin
                    if (tick) begin
                        if (st_q.cnt == dir_end) begin
                            st_d.st  = ST_CONV;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        step = 1'b1;
                        if (last) begin
                            finish  = 1'b1;
                            st_d.st = ST_IDLE;
                        end
                    end
                end
                default: st_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st  <= ST_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sar_timing_seq.sv
module sar_timing_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned     RES_W     = 10,
    parameter int unsigned     LOW_DROP  = 2,
    parameter logic [CFG_W-1:0] CFG_RESET = 8'h05
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             start,
    input  logic             cmp_in,
    output logic             samp_buf,
    output logic             samp_dir,
    output logic             conv_act,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             busy
);
    typedef struct packed {
        seq_cfg_t         cfg;
        logic [RES_W-1:0] res;
        logic             done;
    } top_st_t;

    top_st_t          st_d, st_q;
    seq_state_e       state;
    logic             tick, restart, step, finish, last;
    logic [RES_W-1:0] trial, decided;

    sar_tick_gen #(.PRS_W(PRS_W)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (busy),
        .prs     (st_q.cfg.prs),
        .tick    (tick)
    );

    sar_seq_fsm #(.SMP_W(SMP_W)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (cfg_we),
        .tick    (tick),
        .smp_len (st_q.cfg.smp_len),
        .last    (last),
        .state   (state),
        .restart (restart),
        .step    (step),
        .finish  (finish)
    );

    sar_approx_reg #(.RES_W(RES_W), .LOW_DROP(LOW_DROP)) i_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .step       (step),
        .cmp        (cmp_in),
        .short_mode (st_q.cfg.res_low),
        .trial      (trial),
        .decided    (decided),
        .last       (last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (cfg_we) begin
            st_d.cfg = seq_cfg_t'(cfg_wdata);
        end
        // finish is never raised in a write cycle: the sequencer treats the write as abort.
        if (finish) begin
            st_d.res  = decided;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= seq_cfg_t'(CFG_RESET);
            st_q.res  <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign samp_buf  = (state == ST_BUF);
    assign samp_dir  = (state == ST_DIR);
    assign conv_act  = (state == ST_CONV);
    assign dac_code  = conv_act ? trial : '0;
    assign cfg_rdata = st_q.cfg;
    assign result    = st_q.res;
    assign done      = st_q.done;

endmodule

// File: rtl/sar_timing_seq_chk.sv
module sar_timing_seq_chk #(
    parameter int unsigned RES_W    = 10,
    parameter int unsigned LOW_DROP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             start,
    input logic [7:0]       cfg_rdata,
    input logic             samp_buf,
    input logic             samp_dir,
    input logic             conv_act,
    input logic [RES_W-1:0] dac_code,
    input logic [RES_W-1:0] result,
    input logic             done,
    input logic             busy
);
    localparam logic [RES_W-1:0] TOP_BIT  = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] LOW_MASK = RES_W'((1 << LOW_DROP) - 1);

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({samp_buf, samp_dir, conv_act}));

    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> (!busy && !done));

    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cfg_we) |=> (busy && samp_buf));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    assert_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_rdata[7]) |-> ((result & LOW_MASK) == '0));

    assert_first_trial_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_act) |-> (dac_code == TOP_BIT));

    assert_buf_to_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(samp_buf) && busy) |-> samp_dir);

endmodule

bind sar_timing_seq sar_timing_seq_chk #(.RES_W(RES_W), .LOW_DROP(LOW_DROP)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .start     (start),
    .cfg_rdata (cfg_rdata),
    .samp_buf  (samp_buf),
    .samp_dir  (samp_dir),
    .conv_act  (conv_act),
    .dac_code  (dac_code),
    .result    (result),
    .done      (done),
    .busy      (busy)
);

// File: tb/test_sar_timing_seq.sv
`timescale 1ns/1ps
module test_sar_timing_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       start = 1'b0;
    logic [9:0] ana = 10'd0;
    logic       cmp_in;
    logic [7:0] cfg_rdata;
    logic       samp_buf, samp_dir, conv_act, done, busy;
    logic [9:0] dac_code, result;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    // Comparator model: high when the held input is at or above the trial code.
    assign cmp_in = (ana >= dac_code);

    sar_timing_seq i_sar_timing_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .start(start), .cmp_in(cmp_in),
        .samp_buf(samp_buf), .samp_dir(samp_dir), .conv_act(conv_act),
        .dac_code(dac_code), .result(result), .done(done), .busy(busy)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cfg_rdata", cfg_rdata, 8'h05);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);
        chk("R1 strobes", {samp_buf, samp_dir, conv_act}, 0);
    endtask

    task automatic t_regs();
        write_cfg(8'hA7);
        chk("R2 readback A7", cfg_rdata, 8'hA7);
        write_cfg(8'h5A);
        chk("R2 readback 5A", cfg_rdata, 8'h5A);
    endtask

    task automatic run_conv(bit res_low, bit [1:0] smp, bit [4:0] prs, bit [9:0] v);
        int d, n2, nb, exp_res, nbuf, ndir, ncv, nbusy, guard;
        d       = 2 * (int'(prs) + 1);
        n2      = 2 << smp;
        nb      = res_low ? 8 : 10;
        exp_res = res_low ? int'(v & 10'h3FC) : int'(v);
        write_cfg({res_low, smp, prs});
        chk("R2 cfg layout", cfg_rdata, int'({res_low, smp, prs}));
        ana = v;
        pulse_start();
        chk("R4 buffered phase starts", samp_buf, 1);
        chk("R7 first trial code", dac_code, 0);
        nbuf = 0; ndir = 0; ncv = 0; nbusy = 0; guard = 0;
        while (busy && guard < 5000) begin
            nbuf  += int'(samp_buf);
            ndir  += int'(samp_dir);
            ncv   += int'(conv_act);
            nbusy++;
            if (done) chk("R9 done while busy", 1, 0);
            @(negedge clk);
            guard++;
        end
        chk("R4 buffered length", nbuf, 2 * d);
        chk("R5 direct length", ndir, n2 * d);
        chk("R6 decision length", ncv, nb * d);
        chk("R3 busy length", nbusy, d * (2 + n2 + nb));
        chk("R9 done after busy", done, 1);
        chk(res_low ? "R8 left-aligned result" : "R7 result", result, exp_res);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
        chk("R9 result held", result, exp_res);
    endtask

    task automatic t_abort();
        logic [9:0] prev;
        int ndone;
        prev = result;
        write_cfg(8'h00);
        ana = 10'h155;
        pulse_start();
        repeat (9) @(negedge clk);
        chk("R11 still busy before write", busy, 1);
        cfg_we    = 1'b1;
        cfg_wdata = 8'h45;
        @(negedge clk);
        cfg_we    = 1'b0;
        chk("R11 busy drops", busy, 0);
        chk("R11 write taken", cfg_rdata, 8'h45);
        ndone = 0;
        for (int i = 0; i < 60; i++) begin
            ndone += int'(done) + int'(busy);
            @(negedge clk);
        end
        chk("R11 no done or restart", ndone, 0);
        chk("R11 result kept", result, prev);
    endtask

    task automatic t_start_busy();
        int nbusy, guard;
        write_cfg(8'h01);
        ana = 10'h0F0;
        pulse_start();
        nbusy = 0; guard = 0;
        while (busy && guard < 5000) begin
            if (nbusy == 20) start = 1'b1;
            else start = 1'b0;
            nbusy++;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk("R10 start while busy ignored", nbusy, 4 * 14);
        chk("R10 result", result, 10'h0F0);
    endtask

    task automatic t_start_write();
        @(negedge clk);
        start     = 1'b1;
        cfg_we    = 1'b1;
        cfg_wdata = 8'h02;
        @(negedge clk);
        start  = 1'b0;
        cfg_we = 1'b0;
        chk("R11 start dropped on write", busy, 0);
        repeat (5) @(negedge clk);
        chk("R11 still idle", busy, 0);
        chk("R11 cfg written", cfg_rdata, 8'h02);
    endtask

    initial begin
        #800000;
        chk("watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        run_conv(1'b0, 2'd0, 5'd0,  10'h2A5);
        run_conv(1'b0, 2'd1, 5'd5,  10'h3FF);
        run_conv(1'b1, 2'd3, 5'd2,  10'h1FF);
        run_conv(1'b0, 2'd2, 5'd1,  10'h000);
        run_conv(1'b1, 2'd0, 5'd31, 10'h003);
        run_conv(1'b1, 2'd1, 5'd0,  10'h2AA);
        t_abort();
        t_start_busy();
        t_start_write();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule